// File: doc/BRIEF.md
# Wrapping Bit-Field Extract and Insert Unit

This unit operates on one 32-bit register word and a bit field inside it. The field is named by a starting offset and a width. Field positions are counted from the most significant bit of the word, so position 0 is bit 31 in ordinary integer numbering. A field that runs past the least significant bit continues from the top of the same word.

The operation select picks one of three actions. The unit can read the field out right-justified with zero fill. It can read the field out right-justified with its top bit copied upward. It can also write the low bits of an insert value into the field and leave the rest of the word as it was. Each operation also produces a zero flag and a negative flag for the field. The caller pulses a start strobe with the inputs, and one cycle later the result and flags are held in registers with a valid flag.

Top module: `bitfield_unit`

## Requirements
- R1: The width input (`wid_i`, 5 bits) encodes field widths 1 to 31 directly, and code 0 selects a full 32-bit field.
- R2: Field position p (offset 0 to 31) maps to integer bit 31-p. With offset 0 and width 8, the field is bits 31 down to 24, and bit 31 is the most significant bit of the field.
- R3: When offset plus width exceeds 32, the field continues at position 0 (bit 31) of the same word. The lowest field bit sits at position (offset+width-1) mod 32.
- R4: Op code 0 (and the reserved code 3) returns the field right-justified with all upper bits zero.
- R5: Op code 1 returns the field right-justified, with every bit above the field set to the field's top bit.
- R6: Op code 2 returns the operand with the field bits replaced by the low width bits of `ins_i`, the top of those bits landing at the offset position. All other bits are unchanged.
- R7: `zero_o` is 1 exactly when the field value is all zero. For insert, the field value is the inserted value.
- R8: `neg_o` equals the top bit of the field value. For insert, the field value is the inserted value.
- R9: `valid_o` is high for exactly the one cycle following a cycle in which `start_i` is high.
- R10: While `start_i` is low, `result_o`, `zero_o` and `neg_o` keep their values.
- R11: While `rst_n` is low, `result_o`, `valid_o`, `zero_o` and `neg_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation on the inputs of this cycle |
| op_i | input | 2 | 0 unsigned extract, 1 signed extract, 2 insert, 3 as 0 |
| operand_i | input | 32 | Register word holding the field |
| off_i | input | 5 | Field offset, counted from the MSB |
| wid_i | input | 5 | Field width, 0 meaning 32 |
| ins_i | input | 32 | Insert value, low width bits used |
| result_o | output | 32 | Extracted field or updated word |
| valid_o | output | 1 | Result valid, one cycle after start |
| zero_o | output | 1 | Field value is zero |
| neg_o | output | 1 | Top bit of the field value |

## Verification
The result, both flags and the valid flag all come from one register stage. Each of them is therefore due at the first rising edge after the cycle in which start is high, and valid falls again at the edge after that. The bench applies inputs on the falling edge, samples on the falling edge that follows the loading edge, and checks one cycle later that valid has dropped and that the outputs hold. Expected values come from a bit-by-bit walk over field positions in the bench, with hand-worked values for the wrap, full-width and sign cases.

// File: rtl/bf_pkg.sv
package bf_pkg;
   typedef enum logic [1:0] {
      BF_EXTU = 2'd0,
      BF_EXTS = 2'd1,
      BF_INS  = 2'd2,
      BF_RSVD = 2'd3
   } bf_op_e;
endpackage

// File: rtl/bf_rotate.sv
module bf_rotate #(
   parameter int W    = 32,
   parameter bit LEFT = 1'b1,
   localparam int AW  = $clog2(W)
) (
   input  logic [W-1:0]  d_i,
   input  logic [AW-1:0] amt_i,
   output logic [W-1:0]  d_o
);
   logic [2*W-1:0] dbl;
   generate
      if (LEFT) begin : g_left
         always_comb begin
            dbl = {d_i, d_i} << amt_i;
            d_o = dbl[2*W-1:W];
         end
      end else begin : g_right
         always_comb begin
            dbl = {d_i, d_i} >> amt_i;
            d_o = dbl[W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/bf_lowmask.sv
module bf_lowmask #(
   parameter int W   = 32,
   localparam int AW = $clog2(W)
) (
   input  logic [AW-1:0] wid_i,
   output logic [W-1:0]  mask_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign mask_o[i] = (wid_i == '0) || (AW'(i) < wid_i);
   end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [AW-1:0]     off_i,
   input  logic [AW-1:0]     wid_i,
   input  logic [DATA_W-1:0] ins_i,
   output logic [DATA_W-1:0] result_o,
   output logic              valid_o,
   output logic              zero_o,
   output logic              neg_o
);
   import bf_pkg::*;

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("bitfield_unit: DATA_W must be a power of two of at least 2");
   end

   bf_op_e            op;
   logic [AW-1:0]     shamt;
   logic [AW-1:0]     top_idx;
   logic [DATA_W-1:0] low_mask;
   logic [DATA_W-1:0] field_mask;
   logic [DATA_W-1:0] aligned;
   logic [DATA_W-1:0] fval;
   logic [DATA_W-1:0] ins_low;
   logic [DATA_W-1:0] ins_placed;
   logic [DATA_W-1:0] nxt_result;
   logic              nxt_zero;
   logic              nxt_neg;

   assign op      = bf_op_e'(op_i);
   // the rotate amount wraps naturally: width code 0 stands for DATA_W
   assign shamt   = off_i + wid_i;
   assign top_idx = wid_i - 1'b1;

   bf_lowmask #(.W(DATA_W)) u_mask (.wid_i(wid_i), .mask_o(low_mask));

   bf_rotate #(.W(DATA_W), .LEFT(1'b1)) u_rot_ext (
      .d_i(operand_i), .amt_i(shamt), .d_o(aligned));

   bf_rotate #(.W(DATA_W), .LEFT(1'b0)) u_rot_mask (
      .d_i(low_mask), .amt_i(shamt), .d_o(field_mask));

   assign ins_low = ins_i & low_mask;

   bf_rotate #(.W(DATA_W), .LEFT(1'b0)) u_rot_ins (
      .d_i(ins_low), .amt_i(shamt), .d_o(ins_placed));

   assign fval = aligned & low_mask;

   always_comb begin
      unique case (op)
         BF_EXTS: begin
            nxt_neg    = fval[top_idx];
            nxt_zero   = (fval == '0);
            nxt_result = nxt_neg ? (fval | ~low_mask) : fval;
         end
         BF_INS: begin
            nxt_neg    = ins_low[top_idx];
            nxt_zero   = (ins_low == '0);
            nxt_result = (operand_i & ~field_mask) | (ins_placed & field_mask);
         end
         default: begin
            nxt_neg    = fval[top_idx];
            nxt_zero   = (fval == '0);
            nxt_result = fval;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         zero_o   <= 1'b0;
         neg_o    <= 1'b0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= start_i;
         if (start_i) begin
            result_o <= nxt_result;
            zero_o   <= nxt_zero;
            neg_o    <= nxt_neg;
         end
      end
   end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [1:0]        op_i,
   input logic [DATA_W-1:0] operand_i,
   input logic [DATA_W-1:0] field_mask,
   input logic [DATA_W-1:0] result_o,
   input logic              valid_o,
   input logic              zero_o,
   input logic              neg_o
);
   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);
   assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !valid_o);
   assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(result_o) && $stable(zero_o) && $stable(neg_o)));
   assert_insert_keeps_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 2'd2) |=>
         ((result_o & ~$past(field_mask)) == ($past(operand_i) & ~$past(field_mask))));
   assert_extract_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i != 2'd2) |=> (zero_o == (result_o == '0)));
   assert_signed_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 2'd1) |=> (neg_o == result_o[DATA_W-1]));
endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
   .operand_i(operand_i), .field_mask(field_mask), .result_o(result_o),
   .valid_o(valid_o), .zero_o(zero_o), .neg_o(neg_o));

// File: tb/bitfield_unit_test.sv
`timescale 1ns/1ps
module bitfield_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = '0;
   logic [31:0] operand_i = '0;
   logic [4:0]  off_i = '0;
   logic [4:0]  wid_i = '0;
   logic [31:0] ins_i = '0;
   logic [31:0] result_o;
   logic        valid_o, zero_o, neg_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bitfield_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .operand_i(operand_i), .off_i(off_i), .wid_i(wid_i), .ins_i(ins_i),
      .result_o(result_o), .valid_o(valid_o), .zero_o(zero_o), .neg_o(neg_o));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // independent model: walk the field from its top bit downward
   function automatic logic [31:0] model_field(logic [31:0] w, int off, int wid);
      logic [31:0] f = '0;
      int n = (wid == 0) ? 32 : wid;
      for (int j = 0; j < n; j++) begin
         int pos = (off + j) % 32;
         f[n-1-j] = w[31-pos];
      end
      return f;
   endfunction

   function automatic logic [31:0] model_insert(logic [31:0] w, logic [31:0] v,
                                                int off, int wid);
      logic [31:0] r = w;
      int n = (wid == 0) ? 32 : wid;
      for (int j = 0; j < n; j++) begin
         int pos = (off + j) % 32;
         r[31-pos] = v[n-1-j];
      end
      return r;
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [31:0] w,
                         input int off, input int wid, input logic [31:0] v);
      @(negedge clk);
      op_i = op; operand_i = w; off_i = 5'(off); wid_i = 5'(wid); ins_i = v;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // compare outputs against the model; call right after run_op
   task automatic check_model(input logic [1:0] op, input logic [31:0] w,
                              input int off, input int wid, input logic [31:0] v,
                              input string req);
      int n = (wid == 0) ? 32 : wid;
      logic [31:0] f, exp;
      logic ez, en;
      if (op == 2'd2) begin
         f   = model_field(model_insert(w, v, off, wid), off, wid);
         exp = model_insert(w, v, off, wid);
      end else begin
         f   = model_field(w, off, wid);
         exp = f;
         if (op == 2'd1 && f[n-1] && n < 32) exp = f | ~((32'd1 << n) - 32'd1);
      end
      ez = (f == 0);
      en = f[n-1];
      chk(valid_o == 1'b1, {req, " R9 valid"}, 32'(valid_o), 32'd1);
      chk(result_o == exp, {req, " result"}, result_o, exp);
      chk(zero_o == ez, {req, " R7 zero"}, 32'(zero_o), 32'(ez));
      chk(neg_o == en, {req, " R8 neg"}, 32'(neg_o), 32'(en));
   endtask

   task automatic t_reset();
      #1;
      chk(result_o == 0, "R11 result", result_o, 0);
      chk(valid_o == 0 && zero_o == 0 && neg_o == 0, "R11 flags",
          {29'd0, valid_o, zero_o, neg_o}, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_msb_numbering();
      run_op(2'd0, 32'hA5C3_0F11, 0, 8, 0);
      chk(result_o == 32'h0000_00A5, "R2 R4 top byte", result_o, 32'hA5);
      check_model(2'd0, 32'hA5C3_0F11, 0, 8, 0, "R2");
      run_op(2'd3, 32'hA5C3_0F11, 8, 8, 0);
      chk(result_o == 32'h0000_00C3, "R4 reserved code", result_o, 32'hC3);
   endtask

   task automatic t_wrap();
      run_op(2'd0, 32'hF000_000A, 28, 8, 0);
      chk(result_o == 32'h0000_00AF, "R3 wrap extract", result_o, 32'hAF);
      run_op(2'd2, 32'hFFFF_FFFF, 30, 4, 0);
      chk(result_o == 32'h3FFF_FFFC, "R3 R6 wrap insert", result_o, 32'h3FFF_FFFC);
      chk(zero_o == 1'b1, "R7 insert zero", 32'(zero_o), 1);
   endtask

   task automatic t_full_width();
      run_op(2'd0, 32'h1234_5678, 4, 0, 0);
      chk(result_o == 32'h2345_6781, "R1 full width", result_o, 32'h2345_6781);
      run_op(2'd0, 32'h1234_5678, 4, 31, 0);
      chk(result_o == 32'h11A2_B3C0, "R1 width 31", result_o, 32'h11A2_B3C0);
   endtask

   task automatic t_sign();
      run_op(2'd1, 32'h8000_0000, 0, 4, 0);
      chk(result_o == 32'hFFFF_FFF8, "R5 sign fill", result_o, 32'hFFFF_FFF8);
      chk(neg_o == 1'b1, "R8 neg set", 32'(neg_o), 1);
      run_op(2'd1, 32'h7000_0000, 0, 4, 0);
      chk(result_o == 32'h0000_0007, "R5 positive", result_o, 7);
      run_op(2'd1, 32'h0F00_0000, 0, 4, 0);
      chk(zero_o == 1'b1 && result_o == 0, "R7 zero field", result_o, 0);
   endtask

   task automatic t_insert();
      run_op(2'd2, 32'h0000_0000, 4, 8, 32'hFFFF_FF9C);
      chk(result_o == 32'h09C0_0000, "R6 insert", result_o, 32'h09C0_0000);
      chk(neg_o == 1'b1 && zero_o == 1'b0, "R8 insert neg",
          {30'd0, neg_o, zero_o}, 2);
   endtask

   task automatic t_hold();
      logic [31:0] keep;
      run_op(2'd0, 32'hDEAD_BEEF, 16, 16, 0);
      keep = result_o;
      @(negedge clk);
      chk(valid_o == 1'b0, "R9 valid drops", 32'(valid_o), 0);
      operand_i = 32'h0; off_i = 5'd3; op_i = 2'd2;
      repeat (3) @(negedge clk);
      chk(result_o == keep && valid_o == 1'b0, "R10 hold", result_o, keep);
   endtask

   task automatic t_sweep();
      for (int k = 0; k < 60; k++) begin
         logic [1:0]  op = 2'($urandom_range(0, 2));
         logic [31:0] w = $urandom;
         logic [31:0] v = $urandom;
         int off = $urandom_range(0, 31);
         int wid = $urandom_range(0, 31);
         run_op(op, w, off, wid, v);
         check_model(op, w, off, wid, v, "R3 R4 R5 R6 sweep");
      end
   endtask

   initial begin
      t_reset();
      t_msb_numbering();
      t_wrap();
      t_full_width();
      t_sign();
      t_insert();
      t_hold();
      t_sweep();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule